// File: doc/BRIEF.md
# Flash Command Front End with Write Lockout

This block sits between the host bus and the internal write engine of a parallel NOR-style flash device. It captures one command byte on every cycle in which both the write-enable and chip-enable inputs are low. It tracks the two-cycle program and erase sequences and sends a one-cycle start request to the write engine. It selects whether the data output shows the memory array or a status byte. The write engine and the memory array are outside the block. Their busy level and read data arrive as inputs.

Supply and reset-pin conditions arrive as digital flags. A rail that has fallen below the lockout threshold blocks every write and forces the block back to array reads. A program or erase confirmed while a supply is bad, or while the reset pin is at an undefined level, is refused and flagged in status. Pulling the reset pin low disables the block. If an operation is in flight, the block holds busy and requests an abort from the engine, then enters deep power-down and wipes status. After the pin rises, a fixed count of wake-up cycles passes before commands are accepted again.

Top module: `flash_cmd_front`

## Requirements
- R1: A bus write is taken only in a cycle where `bus_we_n` and `bus_ce_n` are both 0. If either is 1, the byte has no effect.
- R2: Byte 0xFF selects array reads, so `bus_q` equals `array_q`. Byte 0x70 selects status reads, so `bus_q` equals the status byte. The status byte has bit 7 = ready (1 when idle), bit 5 = erase error, bit 4 = program error, bit 3 = VPP error, and all other bits 0.
- R3: Byte 0x40 followed by a data byte pulses `start_prog` for one cycle, in the cycle after the data write. `prog_data` then holds that data byte.
- R4: Byte 0x20 followed by 0xD0 pulses `start_erase` for one cycle. Byte 0x20 followed by any other byte sets status bits 4 and 5 and starts nothing.
- R5: If `vpp_ok` is 0 at a program or erase confirm, no start is issued. Status bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R6: If `vcc_ok` or `rst_pin_valid` is 0 at a confirm, no start is issued. Only bit 4 (program) or bit 5 (erase) is set.
- R7: Status bits 3, 4 and 5 stay set until byte 0x50 is written or the status register is cleared by reset or power-down.
- R8: When `rst_pin_low` rises during an operation, `ry_by` stays 0 and `abort_req` stays 1 until `wsm_busy` falls. The block then raises `deep_pd`.
- R9: Deep power-down clears status bits 3 to 5 and returns reads to the array.
- R10: After `rst_pin_low` falls, bus writes are ignored for WAKE_CYC cycles.
- R11: While `vcc_lko` is 1, bus writes are ignored, reads return to the array, and a pending setup byte is discarded.
- R12: The read selection is not changed by VPP transitions, chip-enable activity or engine activity. After an operation ends, reads stay on status until 0xFF is written.
- R13: After `rst_n` reset, reads show the array, status bits 3 to 5 are 0, `deep_pd` is 0, and no start is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_we_n | input | 1 | Write enable, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_d | input | 8 | Command or data byte from the host |
| bus_q | output | 8 | Read data: array byte or status byte |
| array_q | input | 8 | Read data from the array model |
| vcc_ok | input | 1 | Core supply within its operating range |
| vcc_lko | input | 1 | Core supply below the lockout level |
| vpp_ok | input | 1 | Programming supply within range |
| rst_pin_low | input | 1 | Reset pin driven low |
| rst_pin_valid | input | 1 | Reset pin at a valid high or high-voltage level |
| wsm_busy | input | 1 | Write engine busy |
| start_prog | output | 1 | One-cycle program start request |
| start_erase | output | 1 | One-cycle erase start request |
| prog_data | output | 8 | Data byte for the program request |
| abort_req | output | 1 | Abort request to the engine while the reset pin is low |
| ry_by | output | 1 | Ready (1) or busy (0) |
| deep_pd | output | 1 | Deep power-down active |

## Verification
The assertions assume that `wsm_busy` rises only after a start request and that it falls some time after `abort_req` rises. They also assume that `rst_pin_low` and `rst_pin_valid` are never both 1. The bench's write-engine model raises busy one cycle after each start pulse. It shortens the remaining count to a few cycles once it sees an abort request. The bench changes supply and reset-pin flags only on falling edges, holds each bus write low for exactly one cycle, and never sends a new setup byte while the engine is busy.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and state types for the flash command front end.
// Assumes byte-wide commands on the host bus.
package flash_cmd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [BYTE_W-1:0] CMD_READ_STAT  = 8'h70;
    localparam logic [BYTE_W-1:0] CMD_CLEAR_STAT = 8'h50;
    localparam logic [BYTE_W-1:0] CMD_PROG_SETUP = 8'h40;
    localparam logic [BYTE_W-1:0] CMD_ERASE_SET  = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_ERASE_CONF = 8'hD0;

    typedef enum logic [1:0] {PW_RUN, PW_ABORT, PW_DPD, PW_WAKE} pwr_state_t;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_state_t;
endpackage

// File: rtl/flash_pwr_ctrl.sv
// Reset-pin sequencer. It runs normally, aborts an in-flight operation when
// the pin drops, holds deep power-down while the pin is low, then waits
// WAKE_CYC cycles before it enables commands again.
// Assumes that wsm_busy falls some time after abort is requested.
module flash_pwr_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int WAKE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_low,
    input  logic       wsm_busy,
    output pwr_state_t state,
    output logic       cmd_enable,
    output logic       pwr_clr
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] wake_cnt;

    // State transitions of the reset-pin sequencer and the wake-up counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PW_RUN;
            wake_cnt <= '0;
        end else begin
            case (state)
                PW_RUN:   if (pin_low) state <= wsm_busy ? PW_ABORT : PW_DPD;
                PW_ABORT: if (!wsm_busy) state <= PW_DPD;
                PW_DPD: begin
                    wake_cnt <= '0;
                    if (!pin_low) state <= PW_WAKE;
                end
                PW_WAKE: begin
                    if (pin_low) begin
                        state <= PW_DPD;
                    end else if (wake_cnt == WAKE_LAST) begin
                        state <= PW_RUN;
                    end else begin
                        wake_cnt <= wake_cnt + 1'b1;
                    end
                end
                default: state <= PW_RUN;
            endcase
        end
    end

    // Commands are allowed only in normal running with the pin released.
    always_comb begin
        cmd_enable = (state == PW_RUN) && !pin_low;
        pwr_clr    = (state == PW_ABORT) || (state == PW_DPD);
    end

    a_r8_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_RUN && pin_low && wsm_busy) |=> (state == PW_ABORT));
    a_r8_abort_to_dpd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_ABORT && !wsm_busy) |=> (state == PW_DPD));
    a_r10_dpd_not_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_DPD) |=> (state != PW_RUN));
endmodule

// File: rtl/flash_cmd_decode.sv
// Command sequencer. It decodes single-byte commands and the two-cycle
// program and erase sequences, drives the read selection, issues registered
// start pulses and raises one-cycle error-set strobes for status.
// Assumes that wr_acc is high for exactly one cycle per host write.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flush,
    input  logic              ok_vpp,
    input  logic              ok_other,
    output logic              show_status,
    output logic              start_prog,
    output logic              start_erase,
    output logic [BYTE_W-1:0] prog_data,
    output logic              set_vpp_err,
    output logic              set_prog_err,
    output logic              set_erase_err,
    output logic              clr_cmd
);
    seq_state_t seq;
    logic confirm, bad_code, op_fail, go_prog, go_erase;

    // Classify the current write against the pending sequence.
    always_comb begin
        confirm       = wr_acc && (seq != SEQ_IDLE);
        bad_code      = (seq == SEQ_ERASE) && (wr_data != CMD_ERASE_CONF);
        op_fail       = !ok_vpp || !ok_other;
        go_prog       = confirm && (seq == SEQ_PROG) && !op_fail;
        go_erase      = confirm && (seq == SEQ_ERASE) && !bad_code && !op_fail;
        set_prog_err  = confirm && (((seq == SEQ_PROG) && op_fail) || bad_code);
        set_erase_err = confirm && (seq == SEQ_ERASE) && (bad_code || op_fail);
        set_vpp_err   = confirm && !ok_vpp && !bad_code;
        clr_cmd       = wr_acc && (seq == SEQ_IDLE) && (wr_data == CMD_CLEAR_STAT);
    end

    // Sequence state, read selection and start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            seq         <= SEQ_IDLE;
            show_status <= 1'b0;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
        end else begin
            start_prog  <= go_prog;
            start_erase <= go_erase;
            if (confirm) begin
                seq <= SEQ_IDLE;
            end else if (wr_acc) begin
                case (wr_data)
                    CMD_READ_ARRAY: show_status <= 1'b0;
                    CMD_READ_STAT:  show_status <= 1'b1;
                    CMD_PROG_SETUP: begin seq <= SEQ_PROG;  show_status <= 1'b1; end
                    CMD_ERASE_SET:  begin seq <= SEQ_ERASE; show_status <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    // Capture the program data byte with its start request.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_data <= '0;
        else if (go_prog) prog_data <= wr_data;
    end

    a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase}));
    a_r5_start_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> $past(ok_vpp && ok_other));
    a_r11_no_start_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!start_prog && !start_erase));
endmodule

// File: rtl/flash_status_reg.sv
// Sticky error bits of the status byte, in the order {erase, program, VPP}.
// Bits are set by strobes from the decoder and cleared by command or by
// power-down. Assumes that a set strobe and a clear command never coincide.
module flash_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_clr,
    input  logic       clr_cmd,
    input  logic       set_vpp_err,
    input  logic       set_prog_err,
    input  logic       set_erase_err,
    output logic [2:0] err_bits
);
    // Accumulate error flags until they are explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_clr || clr_cmd) begin
            err_bits <= '0;
        end else begin
            err_bits <= err_bits | {set_erase_err, set_prog_err, set_vpp_err};
        end
    end

    a_r9_clear_on_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_clr |=> (err_bits == 3'b000));
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_clr && !clr_cmd) |=> ((err_bits & $past(err_bits)) == $past(err_bits)));
endmodule

// File: rtl/flash_cmd_front.sv
// Top of the flash command front end. It gates host writes with the strobes,
// the supply lockout and the reset-pin sequencer, and it builds the status
// byte and the read-data mux. Assumes digital supply flags and that
// rst_pin_low and rst_pin_valid are never both high.
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int WAKE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_n,
    input  logic              bus_ce_n,
    input  logic [BYTE_W-1:0] bus_d,
    output logic [BYTE_W-1:0] bus_q,
    input  logic [BYTE_W-1:0] array_q,
    input  logic              vcc_ok,
    input  logic              vcc_lko,
    input  logic              vpp_ok,
    input  logic              rst_pin_low,
    input  logic              rst_pin_valid,
    input  logic              wsm_busy,
    output logic              start_prog,
    output logic              start_erase,
    output logic [BYTE_W-1:0] prog_data,
    output logic              abort_req,
    output logic              ry_by,
    output logic              deep_pd
);
    pwr_state_t pw_state;
    logic cmd_enable, pwr_clr, wr_acc, show_status;
    logic set_vpp_err, set_prog_err, set_erase_err, clr_cmd;
    logic [2:0] err_bits;
    logic [BYTE_W-1:0] status_byte;

    flash_pwr_ctrl #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pin_low(rst_pin_low), .wsm_busy(wsm_busy),
        .state(pw_state), .cmd_enable(cmd_enable), .pwr_clr(pwr_clr)
    );

    flash_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(bus_d),
        .flush(pwr_clr || vcc_lko), .ok_vpp(vpp_ok),
        .ok_other(vcc_ok && rst_pin_valid), .show_status(show_status),
        .start_prog(start_prog), .start_erase(start_erase), .prog_data(prog_data),
        .set_vpp_err(set_vpp_err), .set_prog_err(set_prog_err),
        .set_erase_err(set_erase_err), .clr_cmd(clr_cmd)
    );

    flash_status_reg u_sts (
        .clk(clk), .rst_n(rst_n), .pwr_clr(pwr_clr), .clr_cmd(clr_cmd),
        .set_vpp_err(set_vpp_err), .set_prog_err(set_prog_err),
        .set_erase_err(set_erase_err), .err_bits(err_bits)
    );

    // Write gating, ready/busy, status byte and read-data selection.
    always_comb begin
        wr_acc      = !bus_we_n && !bus_ce_n && cmd_enable && !vcc_lko;
        abort_req   = (pw_state == PW_ABORT);
        deep_pd     = (pw_state == PW_DPD);
        ry_by       = !wsm_busy && !abort_req;
        status_byte = {ry_by, 1'b0, err_bits, 3'b000};
        bus_q       = show_status ? status_byte : array_q;
    end

    a_r1_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> $past(!bus_we_n && !bus_ce_n));
    a_r11_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_lko |=> !(start_prog || start_erase));
endmodule

// File: tb/flash_cmd_front_bench.sv
`timescale 1ns/1ps
module flash_cmd_front_bench;
    localparam int WAKE = 8;
    localparam int OP_CYC = 12;
    localparam int NVEC = 24;
    localparam logic [7:0] ARR = 8'hA5;

    // Vector layout: {we_n, ce_n, vpp_ok, vcc_ok, data[7:0], expected bus_q[7:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'b00, 2'b11, 8'hFF, 8'hA5}, {2'b00, 2'b11, 8'h70, 8'h80},
        {2'b01, 2'b11, 8'hFF, 8'h80}, {2'b10, 2'b11, 8'hFF, 8'h80},
        {2'b00, 2'b11, 8'hFF, 8'hA5}, {2'b00, 2'b11, 8'h40, 8'h80},
        {2'b00, 2'b11, 8'h3C, 8'h80}, {2'b00, 2'b11, 8'hFF, 8'hA5},
        {2'b00, 2'b11, 8'h20, 8'h80}, {2'b00, 2'b11, 8'hD0, 8'h80},
        {2'b00, 2'b11, 8'h20, 8'h80}, {2'b00, 2'b11, 8'h77, 8'hB0},
        {2'b00, 2'b11, 8'h70, 8'hB0}, {2'b00, 2'b11, 8'h50, 8'h80},
        {2'b00, 2'b01, 8'h40, 8'h80}, {2'b00, 2'b01, 8'h12, 8'h98},
        {2'b00, 2'b11, 8'h50, 8'h80}, {2'b00, 2'b01, 8'h20, 8'h80},
        {2'b00, 2'b01, 8'hD0, 8'hA8}, {2'b00, 2'b11, 8'h50, 8'h80},
        {2'b00, 2'b10, 8'h40, 8'h80}, {2'b00, 2'b10, 8'h55, 8'h90},
        {2'b00, 2'b11, 8'h50, 8'h80}, {2'b00, 2'b11, 8'hFF, 8'hA5}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic we_n = 1'b1, ce_n = 1'b1;
    logic [7:0] d = 8'h00;
    logic vcc_ok = 1'b1, vcc_lko = 1'b0, vpp_ok = 1'b1;
    logic pin_low = 1'b0, pin_valid = 1'b1;
    logic busy;
    logic [7:0] q, pdata;
    logic sp, se, abort_req, ry_by, deep_pd;
    int bcnt;
    int n_vec = 0, n_bad = 0, n_prog = 0, n_erase = 0;

    always #2 clk = ~clk;

    flash_cmd_front #(.WAKE_CYC(WAKE)) u_flash_cmd_front (
        .clk(clk), .rst_n(rst_n), .bus_we_n(we_n), .bus_ce_n(ce_n), .bus_d(d),
        .bus_q(q), .array_q(ARR), .vcc_ok(vcc_ok), .vcc_lko(vcc_lko),
        .vpp_ok(vpp_ok), .rst_pin_low(pin_low), .rst_pin_valid(pin_valid),
        .wsm_busy(busy), .start_prog(sp), .start_erase(se), .prog_data(pdata),
        .abort_req(abort_req), .ry_by(ry_by), .deep_pd(deep_pd)
    );

    // Write-engine model: busy for OP_CYC cycles, cut short on abort.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= 0;
        end else if (sp || se) begin
            busy <= 1'b1;
            bcnt <= OP_CYC;
        end else if (busy) begin
            if (bcnt == 0) busy <= 1'b0;
            else if (abort_req && bcnt > 3) bcnt <= 3;
            else bcnt <= bcnt - 1;
        end
    end

    // Start-pulse counters.
    always @(posedge clk) begin
        if (sp) n_prog <= n_prog + 1;
        if (se) n_erase <= n_erase + 1;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] v, input logic w, input logic c);
        @(negedge clk);
        we_n = w; ce_n = c; d = v;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 bus_q", q, ARR);
        check("R13 ry_by", {7'd0, ry_by}, 8'd1);
        check("R13 deep_pd", {7'd0, deep_pd}, 8'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R12
        for (int i = 0; i < NVEC; i++) begin
            vpp_ok = VEC[i][17];
            vcc_ok = VEC[i][16];
            bus_write(VEC[i][15:8], VEC[i][19], VEC[i][18]);
            wait_idle();
            check($sformatf("table %0d (R1 R2 R3 R4 R5 R6 R7 R12)", i), q, VEC[i][7:0]);
        end
        vpp_ok = 1'b1; vcc_ok = 1'b1;
        check("R3 prog starts", 8'(n_prog), 8'd1);
        check("R3 prog_data", pdata, 8'h3C);
        check("R4 erase starts", 8'(n_erase), 8'd1);

        // R6 reset pin at an undefined level
        pin_valid = 1'b0;
        bus_write(8'h40, 1'b0, 1'b0);
        bus_write(8'h33, 1'b0, 1'b0);
        wait_idle();
        check("R6 pin invalid status", q, 8'h90);
        check("R6 pin invalid no start", 8'(n_prog), 8'd1);
        pin_valid = 1'b1;
        bus_write(8'h50, 1'b0, 1'b0);

        // R11 lockout drops setup and blocks writes
        bus_write(8'h40, 1'b0, 1'b0);
        @(negedge clk);
        vcc_lko = 1'b1;
        bus_write(8'h70, 1'b0, 1'b0);
        vcc_lko = 1'b0;
        @(negedge clk);
        check("R11 lockout read array", q, ARR);
        bus_write(8'h12, 1'b0, 1'b0);
        wait_idle();
        check("R11 setup dropped", 8'(n_prog), 8'd1);
        check("R11 still array", q, ARR);

        // R8 abort on reset pin during program, R2 busy in status
        bus_write(8'h20, 1'b0, 1'b0);
        bus_write(8'h77, 1'b0, 1'b0);
        bus_write(8'h40, 1'b0, 1'b0);
        bus_write(8'h11, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R2 busy status", q, 8'h30);
        pin_low = 1'b1; pin_valid = 1'b0;
        @(negedge clk);
        check("R8 abort_req", {7'd0, abort_req}, 8'd1);
        check("R8 ry_by held low", {7'd0, ry_by}, 8'd0);
        repeat (10) @(negedge clk);
        check("R8 deep_pd", {7'd0, deep_pd}, 8'd1);
        check("R9 reads array", q, ARR);
        pin_low = 1'b0; pin_valid = 1'b1;
        @(negedge clk);
        // R10 write during wake is ignored
        bus_write(8'h70, 1'b0, 1'b0);
        repeat (WAKE + 4) @(negedge clk);
        check("R10 wake write ignored", q, ARR);
        check("R10 deep_pd off", {7'd0, deep_pd}, 8'd0);
        bus_write(8'h70, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 status cleared", q, 8'h80);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule